// File: doc/BRIEF.md
# Watchdog Timer with Selectable Timeout Tap

This block is a watchdog that runs from a slow, free-running clock. Each clock edge advances a fixed base divider. Every time the divider wraps, it advances a 16-bit postscaler. A 4-bit tap select chooses which power-of-two count of the postscaler counts as a timeout. When a timeout is reached, the block emits a one-cycle pulse and then restarts from zero. The pulse goes to the device-reset output when the device is running. It goes to the wake-up output when the device is in a low-power mode.

Both counters go back to zero on any of these:

- a clear command pulse
- a sleep-entry pulse
- an oscillator-failure indication
- the block's own synchronous reset

The watchdog runs when the configuration enable is set. When that input is clear, a software enable decides instead. The oscillator request output is high whenever the watchdog is enabled.

Top module: `wdog_top`

## Requirements
- R1: While `rst` is high, both pulse outputs are low and both counters are held at zero. The cycle after `rst` falls counts as the first counting edge.
- R2: With tap select value n (0 to 15), a timeout occurs exactly PRE_DIV·2^n enabled clock edges after counting starts. PRE_DIV defaults to 128, so select 15 gives a ratio of 1:32,768 on the base period.
- R3: A one-cycle `clr_cmd` pulse zeroes both counters. The next timeout comes a full period after the edge that sampled it.
- R4: A `sleep_enter` pulse zeroes both counters in the same way as `clr_cmd`.
- R5: An `osc_fail` indication zeroes both counters in the same way as `clr_cmd`.
- R6: The watchdog is enabled when `cfg_en` is 1, whatever the value of `sw_en`. When `cfg_en` is 0, `sw_en` alone enables it.
- R7: While disabled, both counters are held at zero and no pulse is produced. After the watchdog is re-enabled, a full period elapses before a timeout.
- R8: `osc_req` is high exactly when the watchdog is enabled.
- R9: A timeout with `pwr_mode` 2'b00 (run) pulses `dev_rst_pulse`. A timeout with `pwr_mode` 2'b01 (idle), 2'b10 (sleep) or 2'b11 (treated as low power) pulses `wake_pulse` instead. The two outputs are never high together.
- R10: Each pulse lasts exactly one cycle. The counters restart from zero, so timeouts repeat every period while nothing clears them.
- R11: When a clear source is sampled on the same edge that would complete a timeout, the clear wins: no pulse is produced and counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow watchdog clock |
| rst | input | 1 | Synchronous active-high reset, also clears the counters |
| cfg_en | input | 1 | Configuration enable; forces the watchdog on |
| sw_en | input | 1 | Software enable, used only while cfg_en is 0 |
| tap_sel | input | 4 | Postscaler tap select, ratio 2^tap_sel |
| clr_cmd | input | 1 | Clear command pulse |
| sleep_enter | input | 1 | Sleep-entry pulse, clears the counters |
| osc_fail | input | 1 | Oscillator failure indication, clears the counters |
| pwr_mode | input | 2 | 00 run, 01 idle, 10 sleep, 11 low power |
| osc_req | output | 1 | Request for the watchdog clock source |
| dev_rst_pulse | output | 1 | One-cycle device reset request |
| wake_pulse | output | 1 | One-cycle wake-up request |

## Verification
The assertions assume that `pwr_mode` is steady during the cycle in which a timeout completes, since it is sampled on that edge. They also assume that PRE_DIV is at least 2, so that two pulses can never fall on adjacent cycles. The stimulus changes the mode only between armed runs, and always well away from a timeout edge. It uses a small PRE_DIV so that every tap, including the largest one, finishes quickly. Clear sources are driven as single-cycle pulses from the falling edge, which also exercises the case where a clear lands on the timeout edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DEF_PRE_DIV = 128;
    localparam int DEF_POST_W  = 16;
    localparam int DEF_SEL_W   = 4;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_SLEEP = 2'b10,
        PM_LOWP  = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic dev_reset;
        logic wake;
    } wdog_evt_t;

    function automatic logic is_low_power(pwr_mode_e m);
        return m != PM_RUN;
    endfunction

    function automatic wdog_evt_t route_event(logic fire, pwr_mode_e m);
        wdog_evt_t e;
        e.dev_reset = fire && !is_low_power(m);
        e.wake      = fire &&  is_low_power(m);
        return e;
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV = wdog_pkg::DEF_PRE_DIV
) (
    input  logic clk,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && !clear && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (clear || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_postscale.sv
module wdog_postscale #(
    parameter int W     = wdog_pkg::DEF_POST_W,
    parameter int SEL_W = wdog_pkg::DEF_SEL_W
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             run,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);
    localparam int NTAP = 1 << SEL_W;

    logic [W-1:0]    cnt;
    logic [NTAP-1:0] tap_hit;

    for (genvar i = 0; i < NTAP; i++) begin : g_tap
        if (i == 0) begin : g_first
            assign tap_hit[i] = 1'b1;
        end else if (i <= W) begin : g_mid
            assign tap_hit[i] = &cnt[i-1:0];
        end else begin : g_over
            assign tap_hit[i] = &cnt;
        end
    end

    assign expire = run && !clear && tick && tap_hit[sel];

    always_ff @(posedge clk) begin
        if (clear || !run) begin
            cnt <= '0;
        end else if (expire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_route.sv
module wdog_route
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      fire,
    input  pwr_mode_e mode,
    output wdog_evt_t evt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= '0;
        end else begin
            evt <= route_event(fire, mode);
        end
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int PRE_DIV = DEF_PRE_DIV,
    parameter int POST_W  = DEF_POST_W,
    parameter int SEL_W   = DEF_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             sw_en,
    input  logic [SEL_W-1:0] tap_sel,
    input  logic             clr_cmd,
    input  logic             sleep_enter,
    input  logic             osc_fail,
    input  logic [1:0]       pwr_mode,
    output logic             osc_req,
    output logic             dev_rst_pulse,
    output logic             wake_pulse
);
    logic      enabled;
    logic      clr_any;
    logic      base_tick;
    logic      expire;
    wdog_evt_t evt;

    // configuration enable dominates; software bit only matters when it is off
    assign enabled = cfg_en ? 1'b1 : sw_en;
    assign clr_any = rst | clr_cmd | sleep_enter | osc_fail;
    assign osc_req = enabled;

    wdog_prescale #(.DIV(PRE_DIV)) u_pre (
        .clk   (clk),
        .clear (clr_any),
        .run   (enabled),
        .tick  (base_tick)
    );

    wdog_postscale #(.W(POST_W), .SEL_W(SEL_W)) u_post (
        .clk    (clk),
        .clear  (clr_any),
        .run    (enabled),
        .tick   (base_tick),
        .sel    (tap_sel),
        .expire (expire)
    );

    wdog_route u_route (
        .clk  (clk),
        .rst  (rst),
        .fire (expire),
        .mode (pwr_mode_e'(pwr_mode)),
        .evt  (evt)
    );

    assign dev_rst_pulse = evt.dev_reset;
    assign wake_pulse    = evt.wake;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic             sw_en,
    input logic [SEL_W-1:0] tap_sel,
    input logic             clr_cmd,
    input logic             sleep_enter,
    input logic             osc_fail,
    input logic [1:0]       pwr_mode,
    input logic             osc_req,
    input logic             dev_rst_pulse,
    input logic             wake_pulse
);
    logic any_pulse;
    assign any_pulse = dev_rst_pulse | wake_pulse;

    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> !any_pulse);

    // R3 R4 R5 R11: a sampled clear source never yields a pulse
    a_r3_clear_blocks: assert property (@(posedge clk) disable iff (rst)
        (clr_cmd || sleep_enter || osc_fail) |=> !any_pulse);

    a_r7_disabled_silent: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !sw_en) |=> !any_pulse);

    a_r8_req_before_pulse: assert property (@(posedge clk) disable iff (rst)
        any_pulse |-> $past(osc_req));

    a_r9_run_gives_reset: assert property (@(posedge clk) disable iff (rst)
        dev_rst_pulse |-> ($past(pwr_mode) == 2'b00));

    a_r9_lowp_gives_wake: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> ($past(pwr_mode) != 2'b00));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(dev_rst_pulse && wake_pulse));

    a_r10_single_cycle: assert property (@(posedge clk) disable iff (rst)
        any_pulse |=> !any_pulse);
endmodule

bind wdog_top wdog_checker #(.SEL_W(SEL_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_en        (cfg_en),
    .sw_en         (sw_en),
    .tap_sel       (tap_sel),
    .clr_cmd       (clr_cmd),
    .sleep_enter   (sleep_enter),
    .osc_fail      (osc_fail),
    .pwr_mode      (pwr_mode),
    .osc_req       (osc_req),
    .dev_rst_pulse (dev_rst_pulse),
    .wake_pulse    (wake_pulse)
);

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
    localparam int CLK_PERIOD = 10;
    localparam int PDIV       = 2;
    localparam int WD_LIMIT   = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       sw_en = 1'b0;
    logic [3:0] tap_sel = 4'd0;
    logic       clr_cmd = 1'b0;
    logic       sleep_enter = 1'b0;
    logic       osc_fail = 1'b0;
    logic [1:0] pwr_mode = 2'b00;
    logic       osc_req;
    logic       dev_rst_pulse;
    logic       wake_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_top #(.PRE_DIV(PDIV), .POST_W(16), .SEL_W(4)) u0 (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .sw_en(sw_en), .tap_sel(tap_sel),
        .clr_cmd(clr_cmd), .sleep_enter(sleep_enter), .osc_fail(osc_fail),
        .pwr_mode(pwr_mode), .osc_req(osc_req), .dev_rst_pulse(dev_rst_pulse),
        .wake_pulse(wake_pulse)
    );

    // {sel[3:0], mode[1:0], cfg, sw, exp_rst, exp_wake}
    localparam logic [9:0] VEC [8] = '{
        {4'd0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'd1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1},
        {4'd3, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1},
        {4'd2, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0},
        {4'd4, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1},
        {4'd2, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0},
        {4'd5, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0},
        {4'd0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1}
    };

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run exceeded %0d cycles (expected completion)", WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(string tag, logic ar, logic aw, logic er, logic ew);
        checks++;
        if (ar !== er || aw !== ew) begin
            errors++;
            $display("FAIL %s: got rst=%b wake=%b expected rst=%b wake=%b", tag, ar, aw, er, ew);
        end
    endtask

    task automatic chk_bit(string tag, logic a, logic e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, a, e);
        end
    endtask

    // clear pulse sampled on the next rising edge; returns one falling edge later
    task automatic arm();
        clr_cmd = 1'b1;
        step(1);
        clr_cmd = 1'b0;
    endtask

    task automatic expect_timeout(string tag, int n, logic er, logic ew);
        step(n - 1);
        chk({tag, " early"}, dev_rst_pulse, wake_pulse, 1'b0, 1'b0);
        step(1);
        chk(tag, dev_rst_pulse, wake_pulse, er, ew);
        step(1);
        chk("R10 pulse one cycle", dev_rst_pulse, wake_pulse, 1'b0, 1'b0);
    endtask

    initial begin
        int n;
        step(3);
        chk("R1 reset outputs", dev_rst_pulse, wake_pulse, 1'b0, 1'b0);
        rst = 1'b0;

        // table walk: R2 R6 R8 R9, vector 5 covers R7
        for (int i = 0; i < 8; i++) begin
            tap_sel  = VEC[i][9:6];
            pwr_mode = VEC[i][5:4];
            cfg_en   = VEC[i][3];
            sw_en    = VEC[i][2];
            n = PDIV << VEC[i][9:6];
            arm();
            chk_bit("R8 osc_req", osc_req, VEC[i][3] | VEC[i][2]);
            expect_timeout("R2 R9 vector", n, VEC[i][1], VEC[i][0]);
        end

        cfg_en = 1'b1; sw_en = 1'b0; tap_sel = 4'd2; pwr_mode = 2'b00;
        n = PDIV << 2;

        // R1: reset mid-count restarts the period
        arm(); step(5);
        rst = 1'b1; step(1); rst = 1'b0;
        expect_timeout("R1 restart", n, 1'b1, 1'b0);

        // R3: clear command mid-count
        arm(); step(5);
        arm();
        expect_timeout("R3 clear", n, 1'b1, 1'b0);

        // R4: sleep entry mid-count
        arm(); step(5);
        sleep_enter = 1'b1; step(1); sleep_enter = 1'b0;
        expect_timeout("R4 sleep entry", n, 1'b1, 1'b0);

        // R5: oscillator failure mid-count
        arm(); step(5);
        osc_fail = 1'b1; step(1); osc_fail = 1'b0;
        expect_timeout("R5 osc fail", n, 1'b1, 1'b0);

        // R11: clear on the timeout edge wins
        arm(); step(n - 1);
        clr_cmd = 1'b1; step(1); clr_cmd = 1'b0;
        chk("R11 clear wins", dev_rst_pulse, wake_pulse, 1'b0, 1'b0);
        expect_timeout("R11 restart", n, 1'b1, 1'b0);

        // R10: periodic timeouts
        arm(); step(n);
        chk("R10 first", dev_rst_pulse, wake_pulse, 1'b1, 1'b0);
        step(n);
        chk("R10 second", dev_rst_pulse, wake_pulse, 1'b1, 1'b0);
        step(1);
        chk("R10 low after", dev_rst_pulse, wake_pulse, 1'b0, 1'b0);

        // R6: software bit ignored while cfg_en is set
        arm();
        sw_en = 1'b1; step(2); sw_en = 1'b0;
        step(n - 3);
        chk("R6 cfg override early", dev_rst_pulse, wake_pulse, 1'b0, 1'b0);
        step(1);
        chk("R6 cfg override", dev_rst_pulse, wake_pulse, 1'b1, 1'b0);
        step(1);

        // R7: disabling mid-count zeroes the counters
        cfg_en = 1'b0; sw_en = 1'b1;
        arm(); step(5);
        sw_en = 1'b0; step(4);
        chk_bit("R8 osc_req off", osc_req, 1'b0);
        chk("R7 disabled", dev_rst_pulse, wake_pulse, 1'b0, 1'b0);
        sw_en = 1'b1;
        expect_timeout("R7 re-enable", n, 1'b1, 1'b0);

        // R2: largest tap
        cfg_en = 1'b1; tap_sel = 4'd15; pwr_mode = 2'b00;
        arm();
        expect_timeout("R2 sel15", PDIV << 15, 1'b1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule